// File: doc/BRIEF.md
# Serial Control Register Slave for an Audio/Video Switch

This block is a write-only two-wire serial slave that holds the control state of a multi-input audio/video switch. It oversamples the serial clock and data lines with a fast system clock, recognises bus start and stop conditions, and accepts only write transfers to its fixed device address. The slave acknowledges each byte by pulling the data line low during the ninth clock.

After the address, the first byte names a register. Every following byte lands in the next register, so a master can load the whole three-register map in one transfer. The register contents are decoded into ready-to-use controls: source selects, a three-level output code, gain settings in dB, per-output mutes and four general-purpose levels.

Two board-level inputs act on the decoded controls without touching the stored values. The external mute input silences all audio outputs. The power-save input pins the third selector to its fallback source.

Top module: `av_switch_ctrl_slave`

## Requirements
- R1: A transfer whose first byte is 0x90 (address 7'h48, R/W bit 0) is acknowledged: `sda_oe_o` goes high after the SCL falling edge that ends bit 8 and stays high through the ninth clock. Every following byte of the transfer is acknowledged the same way.
- R2: If the first byte after a start has a different address or has R/W = 1, the slave never asserts `sda_oe_o` and ignores every later byte until the next start. No register changes.
- R3: A start condition (SDA falls while SCL is high) begins a new transfer at any point, including in the middle of one. A stop condition (SDA rises while SCL is high) ends the transfer. A transfer that stops after the index byte changes no register.
- R4: The byte after the address is the register index. Each data byte is written to the current index, and the index then advances by one.
- R5: A data byte addressed to an index other than 1, 2 or 3 is acknowledged and discarded.
- R6: Register 1 is decoded as follows. Bits [7:6] drive `sel1_o`, bits [5:4] drive `sel2_o` and bits [3:2] drive `sel3_o`. Bits [1:0] drive `lvl_o`: codes 00 and 01 give 0 (high), 10 gives 1 (mid) and 11 gives 2 (low).
- R7: Register 2 is decoded as follows. Bit 7 drives `gpo_o[0]`, bit 6 drives `gpo_o[1]` and bit 5 drives `vid_gain_o` (1 = 6 dB). Bits [4:2] drive `gain_a_db_o`: codes 0 to 4 give 0, 2, 4, 6 and 12, and codes 5 to 7 give 12. Bits [1:0] drive `gain_b_db_o` as twice the code.
- R8: Register 3 is decoded as follows. Bits 7, 6 and 5 drive `vmute_o[0]`, `vmute_o[1]` and `vmute_o[2]`. Bits 4, 3 and 2 drive `amute_o[0]`, `amute_o[1]` and `amute_o[2]`. Bit 1 drives `gpo_o[2]` and bit 0 drives `gpo_o[3]`. A 1 means mute or high.
- R9: While `ext_mute_i` is high, all three `amute_o` bits are 1. `vmute_o` and the stored bits are not affected.
- R10: While `pwr_save_i` is high, `sel3_o` is 2'b01, whatever register 1 holds. The stored value returns when the input drops.
- R11: After reset, all registers are zero, so every decoded output is 0, and `sda_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the bus bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (as seen on the wire) |
| ext_mute_i | input | 1 | Board mute, forces all audio mutes |
| pwr_save_i | input | 1 | Power-save, forces selector 3 to 2'b01 |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| sel1_o | output | 2 | Selector 1 source code |
| sel2_o | output | 2 | Selector 2 source code |
| sel3_o | output | 2 | Selector 3 source code |
| lvl_o | output | 2 | Three-level output: 0 high, 1 mid, 2 low |
| vid_gain_o | output | 1 | Video gain, 1 = 6 dB |
| gain_a_db_o | output | 4 | Audio gain A in dB |
| gain_b_db_o | output | 4 | Audio gain B in dB |
| vmute_o | output | 3 | Video output mutes |
| amute_o | output | 3 | Audio output mutes |
| gpo_o | output | 4 | General-purpose output levels |

## Verification
Some properties can be checked on every cycle, and the assertions cover them. The acknowledge drive never rises while SCL is high, the bit counter stays bounded, an idle slave never drives the line, and an out-of-range write leaves the registers unchanged. The assertions also check that the gain output only takes its legal dB values and that both override inputs win at once. Other behaviour depends on whole bus transfers, and only the bench scenarios show it. This covers address rejection and ignoring bytes until the next start, auto-increment across the map and past its end, repeated start and early stop, and every field position of the decoded registers.

// File: rtl/av_ctrl_pkg.sv
package av_ctrl_pkg;
  localparam logic [6:0] DEV_ADDR  = 7'h48;
  localparam int         NUM_REGS  = 3;
  localparam int         REG_BASE  = 1;
  localparam int         SYNC_LEN  = 2;
  localparam logic [1:0] SEL3_SAVE = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK} bus_state_e;
  typedef enum logic [1:0] {PH_ADDR, PH_IDX, PH_DATA} bus_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import av_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_lvl_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_lvl_i,
  input  logic       sda_rise_i,
  input  logic       sda_fall_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o
);
  bus_state_e state_q;
  bus_phase_e phase_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shift_q;
  logic [7:0] idx_q;
  logic       oe_q;
  logic       start_det, stop_det;

  assign start_det = scl_lvl_i & sda_fall_i;
  assign stop_det  = scl_lvl_i & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      idx_q     <= '0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q   <= ST_RX;
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && bit_cnt_q < 4'd8) begin
              shift_q   <= {shift_q[6:0], sda_lvl_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              unique case (phase_q)
                PH_ADDR: begin
                  if (shift_q == {DEV_ADDR, 1'b0}) begin
                    state_q <= ST_ACK;
                    oe_q    <= 1'b1;
                  end else begin
                    state_q <= ST_IDLE;  // not for us: wait for next start
                  end
                end
                PH_IDX: begin
                  idx_q   <= shift_q;
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= idx_q;
                  wr_data_o <= shift_q;
                  idx_q     <= idx_q + 8'd1;
                  state_q   <= ST_ACK;
                  oe_q      <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              oe_q      <= 1'b0;
              state_q   <= ST_RX;
              bit_cnt_q <= '0;
              phase_q   <= (phase_q == PH_ADDR) ? PH_IDX : PH_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  assert_ack_scl_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_lvl_i);
  assert_bitcnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd8);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
  assert_write_in_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (phase_q == PH_DATA && state_q == ST_ACK));
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter int NREG = 3,
  parameter int BASE = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [7:0]      wr_idx_i,
  input  logic [7:0]      wr_data_i,
  output logic [NREG*8-1:0] regs_o
);
  localparam int LAST = BASE + NREG - 1;
  logic in_range;

  assign in_range = (int'(wr_idx_i) >= BASE) && (int'(wr_idx_i) <= LAST);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      q <= '0;
      else if (wr_en_i && int'(wr_idx_i) == BASE + g)  q <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = q;
  end

  assert_oob_discard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !in_range) |=> $stable(regs_o));
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import av_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [23:0] regs_i,
  input  logic        ext_mute_i,
  input  logic        pwr_save_i,
  output logic [1:0]  sel1_o,
  output logic [1:0]  sel2_o,
  output logic [1:0]  sel3_o,
  output logic [1:0]  lvl_o,
  output logic        vid_gain_o,
  output logic [3:0]  gain_a_db_o,
  output logic [3:0]  gain_b_db_o,
  output logic [2:0]  vmute_o,
  output logic [2:0]  amute_o,
  output logic [3:0]  gpo_o
);
  logic [7:0] r1, r2, r3;
  assign r1 = regs_i[7:0];
  assign r2 = regs_i[15:8];
  assign r3 = regs_i[23:16];

  assign sel1_o = r1[7:6];
  assign sel2_o = r1[5:4];
  assign sel3_o = pwr_save_i ? SEL3_SAVE : r1[3:2];

  always_comb begin
    unique case (r1[1:0])
      2'b10:   lvl_o = 2'd1;
      2'b11:   lvl_o = 2'd2;
      default: lvl_o = 2'd0;
    endcase
  end

  always_comb begin
    unique case (r2[4:2])
      3'd0:    gain_a_db_o = 4'd0;
      3'd1:    gain_a_db_o = 4'd2;
      3'd2:    gain_a_db_o = 4'd4;
      3'd3:    gain_a_db_o = 4'd6;
      default: gain_a_db_o = 4'd12;  // 4..7 saturate
    endcase
  end

  assign vid_gain_o  = r2[5];
  assign gain_b_db_o = {1'b0, r2[1:0], 1'b0};
  assign vmute_o     = {r3[5], r3[6], r3[7]};
  assign amute_o     = {r3[2], r3[3], r3[4]} | {3{ext_mute_i}};
  assign gpo_o       = {r3[0], r3[1], r2[6], r2[7]};

  assert_gain_a_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_a_db_o inside {4'd0, 4'd2, 4'd4, 4'd6, 4'd12});
  assert_ext_mute_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mute_i |-> (amute_o == 3'b111));
  assert_pwr_save_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_save_i |-> (sel3_o == SEL3_SAVE));
endmodule

// File: rtl/av_switch_ctrl_slave.sv
module av_switch_ctrl_slave
  import av_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       ext_mute_i,
  input  logic       pwr_save_i,
  output logic       sda_oe_o,
  output logic [1:0] sel1_o,
  output logic [1:0] sel2_o,
  output logic [1:0] sel3_o,
  output logic [1:0] lvl_o,
  output logic       vid_gain_o,
  output logic [3:0] gain_a_db_o,
  output logic [3:0] gain_b_db_o,
  output logic [2:0] vmute_o,
  output logic [2:0] amute_o,
  output logic [3:0] gpo_o
);
  localparam int REG_BITS = NUM_REGS * 8;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data;
  logic [REG_BITS-1:0] regs;

  i2c_line_sync #(.STAGES(SYNC_LEN)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  i2c_line_sync #(.STAGES(SYNC_LEN)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  i2c_wr_engine u_engine (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data));

  ctrl_regfile #(.NREG(NUM_REGS), .BASE(REG_BASE)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .regs_o(regs));

  ctrl_decode u_dec (
    .clk_i, .rst_ni, .regs_i(regs), .ext_mute_i, .pwr_save_i,
    .sel1_o, .sel2_o, .sel3_o, .lvl_o, .vid_gain_o,
    .gain_a_db_o, .gain_b_db_o, .vmute_o, .amute_o, .gpo_o);
endmodule

// File: tb/av_switch_ctrl_slave_tb.sv
module av_switch_ctrl_slave_tb_top;
  localparam int T = 40;  // quarter bus bit, in system clocks

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, ext_mute = 1'b0, pwr_save = 1'b0;
  logic sda_oe, sda_line, vid_gain;
  logic [1:0] sel1, sel2, sel3, lvl;
  logic [3:0] gain_a, gain_b, gpo;
  logic [2:0] vmute, amute;
  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [7:0] m1 = 0, m2 = 0, m3 = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  av_switch_ctrl_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .ext_mute_i(ext_mute), .pwr_save_i(pwr_save), .sda_oe_o(sda_oe),
    .sel1_o(sel1), .sel2_o(sel2), .sel3_o(sel3), .lvl_o(lvl),
    .vid_gain_o(vid_gain), .gain_a_db_o(gain_a), .gain_b_db_o(gain_b),
    .vmute_o(vmute), .amute_o(amute), .gpo_o(gpo));

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [1:0] e_lvl;
    logic [3:0] e_ga;
    case (m1[1:0]) 2'b10: e_lvl = 1; 2'b11: e_lvl = 2; default: e_lvl = 0; endcase
    case (m2[4:2]) 0: e_ga = 0; 1: e_ga = 2; 2: e_ga = 4; 3: e_ga = 6; default: e_ga = 12; endcase
    chk({req, " sel1"}, 32'(sel1), 32'(m1[7:6]));
    chk({req, " sel2"}, 32'(sel2), 32'(m1[5:4]));
    chk({req, " sel3"}, 32'(sel3), pwr_save ? 32'd1 : 32'(m1[3:2]));
    chk({req, " lvl"}, 32'(lvl), 32'(e_lvl));
    chk({req, " vid_gain"}, 32'(vid_gain), 32'(m2[5]));
    chk({req, " gain_a"}, 32'(gain_a), 32'(e_ga));
    chk({req, " gain_b"}, 32'(gain_b), 32'(m2[1:0]) * 2);
    chk({req, " vmute"}, 32'(vmute), 32'({m3[5], m3[6], m3[7]}));
    chk({req, " amute"}, 32'(amute), 32'({m3[2], m3[3], m3[4]} | {3{ext_mute}}));
    chk({req, " gpo"}, 32'(gpo), 32'({m3[0], m3[1], m2[6], m2[7]}));
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wt(T); scl = 1'b1; wt(T);
    sda_drv = 1'b0; wt(T); scl = 1'b0; wt(T);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wt(T); scl = 1'b1; wt(T);
    sda_drv = 1'b1; wt(2 * T);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wt(T); scl = 1'b1; wt(2 * T); scl = 1'b0; wt(T);
    end
    sda_drv = 1'b1; wt(T); scl = 1'b1; wt(T);
    ack = ~sda_line;
    wt(T); scl = 1'b0; wt(T);
  endtask

  task automatic model_wr(input logic [7:0] idx, input logic [7:0] d);
    case (idx) 8'd1: m1 = d; 8'd2: m2 = d; 8'd3: m3 = d; default: ; endcase
  endtask

  // start, address, index, n data bytes, stop; every ack checked
  task automatic xfer(input string req, input logic [7:0] idx, input int n,
                      input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(8'h90, ack); chk({req, " R1 addr ack"}, 32'(ack), 1);
    send_byte(idx, ack);   chk({req, " R1 index ack"}, 32'(ack), 1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ack); chk({req, " R1 data ack"}, 32'(ack), 1);
      model_wr(idx + 8'(k), d[k]);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R11 sda_oe idle", 32'(sda_oe), 0);
    check_all("R11 reset");
  endtask

  task automatic t_reg1_levels();
    xfer("R6", 8'd1, 1, 8'b10_01_11_00, 0, 0); check_all("R6 lvl code 00");
    xfer("R6", 8'd1, 1, 8'b00_11_10_01, 0, 0); check_all("R6 lvl code 01");
    xfer("R6", 8'd1, 1, 8'b01_10_00_10, 0, 0); check_all("R6 lvl code 10");
    xfer("R6", 8'd1, 1, 8'b11_00_01_11, 0, 0); check_all("R6 lvl code 11");
    chk("R1 released after stop", 32'(sda_oe), 0);
  endtask

  task automatic t_burst();
    xfer("R4", 8'd1, 3, 8'h5A, 8'b10_1_011_11, 8'b1010_1001);
    check_all("R4 R7 R8 burst of three");
    xfer("R4", 8'd2, 2, 8'b01_0_100_01, 8'b0101_0110, 0);
    check_all("R4 R8 burst from index 2");
  endtask

  task automatic t_gain_sat();
    xfer("R7", 8'd2, 1, 8'b000_101_10, 0, 0); check_all("R7 gain code 5");
    chk("R7 gain_a code 5 is 12 dB", 32'(gain_a), 12);
    xfer("R7", 8'd2, 1, 8'b111_111_00, 0, 0); check_all("R7 gain code 7");
    xfer("R7", 8'd2, 1, 8'b000_010_11, 0, 0); check_all("R7 gain code 2");
  endtask

  task automatic t_bad_addr();
    logic ack;
    bus_start();
    send_byte(8'h91, ack); chk("R2 read bit no ack", 32'(ack), 0);
    send_byte(8'h01, ack); chk("R2 ignored byte no ack", 32'(ack), 0);
    send_byte(8'hFF, ack); chk("R2 ignored byte no ack", 32'(ack), 0);
    bus_stop();
    check_all("R2 after read request");
    bus_start();
    send_byte(8'h92, ack); chk("R2 wrong address no ack", 32'(ack), 0);
    send_byte(8'h03, ack); chk("R2 ignored index", 32'(ack), 0);
    send_byte(8'hFF, ack); chk("R2 ignored data", 32'(ack), 0);
    bus_stop();
    check_all("R2 after wrong address");
  endtask

  task automatic t_out_of_range();
    xfer("R5", 8'd5, 1, 8'hFF, 0, 0);
    check_all("R5 index 5 discarded");
    xfer("R5", 8'd0, 1, 8'hFF, 0, 0);
    check_all("R5 index 0 discarded");
    xfer("R5", 8'd3, 2, 8'h0C, 8'hFF, 0);
    check_all("R5 wrap past index 3 discarded");
  endtask

  task automatic t_start_stop();
    logic ack;
    bus_start();
    send_byte(8'h90, ack); send_byte(8'd1, ack);
    bus_stop();
    check_all("R3 stop after index");
    bus_start();
    send_byte(8'h90, ack); send_byte(8'd1, ack);
    send_byte(8'h3C, ack); chk("R3 data ack", 32'(ack), 1);
    model_wr(8'd1, 8'h3C);
    bus_start();  // repeated start mid-transfer
    send_byte(8'h90, ack); chk("R3 addr ack after repeated start", 32'(ack), 1);
    send_byte(8'd3, ack);
    send_byte(8'h81, ack); chk("R3 data ack after repeated start", 32'(ack), 1);
    model_wr(8'd3, 8'h81);
    bus_stop();
    check_all("R3 repeated start");
  endtask

  task automatic t_overrides();
    xfer("R9", 8'd1, 3, 8'b00_00_11_00, 8'h00, 8'b1010_0000);
    ext_mute = 1'b1; wt(4);
    check_all("R9 ext mute on");
    chk("R9 vmute untouched", 32'(vmute), 32'b101);
    ext_mute = 1'b0; wt(4);
    check_all("R9 ext mute off");
    pwr_save = 1'b1; wt(4);
    check_all("R10 power save on");
    chk("R10 sel3 forced", 32'(sel3), 1);
    pwr_save = 1'b0; wt(4);
    check_all("R10 power save off");
    chk("R10 sel3 restored", 32'(sel3), 3);
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    t_reg1_levels();
    t_burst();
    t_gain_sat();
    t_bad_addr();
    t_out_of_range();
    t_start_stop();
    t_overrides();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule